// File: doc/BRIEF.md
# Per-Lane Oversampled Deskew Phase Selector

This block sits on the receive side of a multi-lane serial link. Each lane reaches it as groups of three samples per bit time (3x oversampling), one group per clock. The three samples of a group are ordered earliest first. For each lane the block keeps a short history of samples. From that history it picks one sample per bit time and presents it as the recovered bit. The pick is made at a signed offset, in thirds of a bit, from a nominal centre slot.

Offsets are learned during blanking. While the blanking qualifier and the DC-balance enable are both high, every lane counts the transitions that fall at each of the three sample boundaries. When a training window closes, each lane aims at the slot that lies one third of a bit after its dominant edge, which is the middle third of the bit. It moves its offset one step to that phase, choosing the candidate closest to the current offset. As a result, slow skew drift is followed across the whole range of plus or minus one bit. The offset is frozen during active data. When DC balance is off, the centre slot is used.

Top module: `dsk_phase_sel`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears every offset to 0, every lock flag to 0 and every recovered bit to 0.
- R2: Take the three sample groups captured at the three edges before edge t and form a 9-sample window, with the first sample of the oldest group as index 0. The bit a lane presents after edge t is window sample 4+o, where o is that lane's offset before edge t.
- R3: A training window is TRAIN_CYC consecutive edges at which both `blank_i` and `dc_bal_i` are high. The new offsets and lock flags appear right after the edge that closes the window.
- R4: Boundary 0 lies between the last sample of the previous group and sample 0 of the current group. Boundary 1 lies between samples 0 and 1, and boundary 2 between samples 1 and 2. Each lane counts the transitions at each boundary over the window. The dominant boundary d is the one with the highest count, with the lowest index winning a tie. The target phase is (d+1) mod 3, where offset o has phase (4+o) mod 3.
- R5: Offsets stay within -3..+3 and are coded in 3-bit two's complement, with lane L at `offset_o[3L+2:3L]`. If the target phase is one step after the current phase, the offset moves by +1, or by -2 if it is already +3. If the target phase is two steps after, the offset moves by -1, or by +2 if it is already -3.
- R6: Each lane chooses its offset only from its own samples.
- R7: While `blank_i` is low, offsets do not change. A window that is cut short is discarded.
- R8: While `dc_bal_i` is low, every offset is 0, every lock flag is 0 and no training takes place.
- R9: A window that sees at least one transition on a lane sets that lane's lock flag. A window with no transitions leaves that lane's offset and lock flag unchanged.
- R10: Blanking that lasts longer than one window trains again in back-to-back windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| dc_bal_i | input | 1 | Enables deskew training; when low, the centre slot is forced |
| blank_i | input | 1 | Blanking qualifier; training runs only while it is high |
| samp_i | input | 3*LANES | Three samples per lane, lane L at bits 3L+2:3L, bit 0 earliest |
| bit_o | output | LANES | Recovered bit per lane |
| offset_o | output | 3*LANES | Chosen offset per lane, signed thirds of a bit |
| lock_o | output | LANES | Per-lane lock flag |

## Verification
Each lane carries a pseudo-random bit stream delayed by its own whole number of samples, so the edge phase is the delay mod 3. The delays are swept upward on one lane and downward on another, so that both saturation corners of the offset are reached. Sweeping in opposite directions also separates a correct step rule from one with the sign reversed. A lane held at a constant level separates the no-transition case from a real lock. Blanking bursts that are cut short, last exactly one window, or run for three windows separate discarding, single training and retraining. Turning DC balance off during blanking shows that the centre slot is forced.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  localparam int OVS    = 3;          // samples per bit time
  localparam int HIST_G = 3;          // groups held per lane
  localparam int WIN    = OVS * HIST_G;
  localparam int IDX_W  = $clog2(WIN);
  localparam int CENTRE = 4;          // nominal slot in the window
  localparam int OFF_W  = 3;

  typedef logic signed [OFF_W-1:0] off_t;

  localparam off_t OFF_MAX = 3'sd3;
  localparam off_t OFF_MIN = -3'sd3;

  // phase of the window slot picked by an offset
  function automatic logic [1:0] ph_of(input off_t o);
    int v;
    v = (CENTRE + int'(o)) % OVS;
    return 2'(v);
  endfunction
endpackage

// File: rtl/dsk_lane_hist.sv
module dsk_lane_hist
  import dsk_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OVS-1:0] grp_i,
  input  off_t           off_i,
  output logic           last_o,
  output logic           bit_o
);
  // grp_q[0] oldest group, grp_q[HIST_G-1] newest
  logic [HIST_G-1:0][OVS-1:0] grp_q;
  logic [WIN-1:0]             win;
  logic [IDX_W-1:0]           sel;

  assign win    = grp_q;
  assign sel    = IDX_W'(CENTRE + int'(off_i));
  assign last_o = grp_q[HIST_G-1][OVS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q <= '0;
      bit_o <= 1'b0;
    end else begin
      grp_q <= {grp_i, grp_q[HIST_G-1:1]};
      bit_o <= win[sel];
    end
  end
endmodule

// File: rtl/dsk_edge_count.sv
module dsk_edge_count
  import dsk_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic                    prev_i,
  input  logic [OVS-1:0]          grp_i,
  output logic [OVS-1:0][CW-1:0]  sum_o
);
  logic [OVS-1:0]         flip;
  logic [OVS-1:0][CW-1:0] cnt_q;

  for (genvar p = 0; p < OVS; p++) begin : g_bnd
    if (p == 0) begin : g_first
      assign flip[p] = prev_i ^ grp_i[0];
    end else begin : g_inner
      assign flip[p] = grp_i[p-1] ^ grp_i[p];
    end
    assign sum_o[p] = cnt_q[p] + CW'(en_i & flip[p]);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else              cnt_q <= sum_o;
  end
endmodule

// File: rtl/dsk_phase_pick.sv
module dsk_phase_pick
  import dsk_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dcb_i,
  input  logic                   done_i,
  input  logic [OVS-1:0][CW-1:0] cnt_i,
  output off_t                   off_o,
  output logic                   lock_o
);
  logic [1:0] dom;
  logic [1:0] tgt;
  logic [1:0] cur;
  logic       any;
  int         dif;
  off_t       nxt;

  always_comb begin
    dom = 2'd0;
    if (cnt_i[1] > cnt_i[0])   dom = 2'd1;
    if (cnt_i[2] > cnt_i[dom]) dom = 2'd2;
    any = |cnt_i;
    tgt = (dom == 2'd2) ? 2'd0 : dom + 2'd1;
    cur = ph_of(off_o);
    dif = (int'(tgt) - int'(cur) + OVS) % OVS;
    case (dif)
      1:       nxt = (off_o == OFF_MAX) ? off_o - 3'sd2 : off_o + 3'sd1;
      2:       nxt = (off_o == OFF_MIN) ? off_o + 3'sd2 : off_o - 3'sd1;
      default: nxt = off_o;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !dcb_i) begin
      off_o  <= '0;
      lock_o <= 1'b0;
    end else if (done_i && any) begin
      off_o  <= nxt;
      lock_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dsk_phase_sel.sv
module dsk_phase_sel
  import dsk_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int TRAIN_CYC = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dc_bal_i,
  input  logic                   blank_i,
  input  logic [LANES*OVS-1:0]   samp_i,
  output logic [LANES-1:0]       bit_o,
  output logic [LANES*OFF_W-1:0] offset_o,
  output logic [LANES-1:0]       lock_o
);
  localparam int CW = $clog2(TRAIN_CYC + 1);

  logic          train_en;
  logic          done;
  logic [CW-1:0] tc_q;

  assign train_en = blank_i & dc_bal_i;
  assign done     = train_en && (tc_q == CW'(TRAIN_CYC - 1));

  // shared window counter: every lane trains over the same cycles
  always_ff @(posedge clk) begin
    if (rst || !train_en || done) tc_q <= '0;
    else                          tc_q <= tc_q + 1'b1;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic                   last;
    logic [OVS-1:0][CW-1:0] sums;
    off_t                   off;
    logic [OVS-1:0]         grp;

    assign grp = samp_i[l*OVS +: OVS];

    dsk_lane_hist u_hist (
      .clk    (clk),
      .rst    (rst),
      .grp_i  (grp),
      .off_i  (off),
      .last_o (last),
      .bit_o  (bit_o[l])
    );

    dsk_edge_count #(.CW(CW)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .clr_i  (done || !train_en),
      .en_i   (train_en),
      .prev_i (last),
      .grp_i  (grp),
      .sum_o  (sums)
    );

    dsk_phase_pick #(.CW(CW)) u_pick (
      .clk    (clk),
      .rst    (rst),
      .dcb_i  (dc_bal_i),
      .done_i (done),
      .cnt_i  (sums),
      .off_o  (off),
      .lock_o (lock_o[l])
    );

    assign offset_o[l*OFF_W +: OFF_W] = off;
  end
endmodule

// File: rtl/dsk_phase_sel_chk.sv
module dsk_phase_sel_chk #(
  parameter int LANES = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 dc_bal_i,
  input logic                 blank_i,
  input logic [LANES-1:0]     bit_o,
  input logic [LANES*3-1:0]   offset_o,
  input logic [LANES-1:0]     lock_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (offset_o == '0 && lock_o == '0 && bit_o == '0));

  p_centre_forced_r8: assert property (@(posedge clk) disable iff (rst)
    !dc_bal_i |=> (offset_o == '0 && lock_o == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_l
    p_in_range_r5: assert property (@(posedge clk) disable iff (rst)
      offset_o[3*l +: 3] != 3'b100);

    p_frozen_active_r7: assert property (@(posedge clk) disable iff (rst)
      (!blank_i && dc_bal_i) |=> $stable(offset_o[3*l +: 3]));

    p_move_means_lock_r9: assert property (@(posedge clk) disable iff (rst)
      dc_bal_i |=> ($stable(offset_o[3*l +: 3]) || lock_o[l]));
  end
endmodule

bind dsk_phase_sel dsk_phase_sel_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .dc_bal_i (dc_bal_i),
  .blank_i  (blank_i),
  .bit_o    (bit_o),
  .offset_o (offset_o),
  .lock_o   (lock_o)
);

// File: tb/dsk_phase_sel_tb_top.sv
module dsk_phase_sel_tb_top;
  localparam int LANES = 4;
  localparam int TRAIN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dcb = 1'b0;
  logic blank = 1'b0;
  logic [LANES*3-1:0] samp = '0;
  logic [LANES-1:0]   bit_o;
  logic [LANES*3-1:0] offset_o;
  logic [LANES-1:0]   lock_o;

  always #10 clk = ~clk;

  dsk_phase_sel #(.LANES(LANES), .TRAIN_CYC(TRAIN)) dut_i (
    .clk(clk), .rst(rst), .dc_bal_i(dcb), .blank_i(blank),
    .samp_i(samp), .bit_o(bit_o), .offset_o(offset_o), .lock_o(lock_o)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int dly [LANES];
  bit quiet [LANES];
  int sidx = 0;
  logic [8:0] hg [LANES];
  int moff [LANES];
  bit mlock [LANES];
  int mcnt [LANES][3];
  int tcnt = 0;
  bit ebit [LANES];

  function automatic bit gen(int n, int l);
    logic [31:0] h;
    h = 32'(n) * 32'h9E3779B1 ^ (32'(l) * 32'h7F4A7C15);
    h = h ^ (h >> 13);
    return h[9];
  endfunction

  task automatic chk(string tag, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
    end
  endtask

  task automatic clear_model();
    tcnt = 0;
    for (int l = 0; l < LANES; l++)
      for (int p = 0; p < 3; p++) mcnt[l][p] = 0;
  endtask

  task automatic decide();
    for (int l = 0; l < LANES; l++) begin
      int dom, tgt, cur, di;
      dom = 0;
      if (mcnt[l][1] > mcnt[l][0]) dom = 1;
      if (mcnt[l][2] > mcnt[l][dom]) dom = 2;
      if (mcnt[l][0] + mcnt[l][1] + mcnt[l][2] > 0) begin
        tgt = (dom + 1) % 3;
        cur = (4 + moff[l]) % 3;
        di  = (tgt - cur + 3) % 3;
        if (di == 1) moff[l] = (moff[l] == 3) ? 1 : moff[l] + 1;
        if (di == 2) moff[l] = (moff[l] == -3) ? -1 : moff[l] - 1;
        mlock[l] = 1'b1;
      end
    end
  endtask

  task automatic step(bit bl, bit d, string tag);
    logic [2:0] g;
    @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      chk("R2", int'(bit_o[l]), int'(ebit[l]), "bit");
      chk(tag, int'($signed(offset_o[3*l +: 3])), moff[l], "offset");
      chk(tag, int'(lock_o[l]), int'(mlock[l]), "lock");
      ebit[l] = hg[l][4 + moff[l]];
    end
    for (int l = 0; l < LANES; l++) begin
      for (int j = 0; j < 3; j++)
        g[j] = quiet[l] ? 1'b0 : gen((3*sidx + j + 24 - dly[l]) / 3, l);
      if (d && bl) begin
        mcnt[l][0] += int'(hg[l][8] ^ g[0]);
        mcnt[l][1] += int'(g[0] ^ g[1]);
        mcnt[l][2] += int'(g[1] ^ g[2]);
      end
      hg[l] = {g, hg[l][8:3]};
      samp[3*l +: 3] = g;
    end
    sidx++;
    if (!d) begin
      clear_model();
      for (int l = 0; l < LANES; l++) begin moff[l] = 0; mlock[l] = 0; end
    end else if (bl) begin
      tcnt++;
      if (tcnt == TRAIN) begin decide(); clear_model(); end
    end else clear_model();
    blank = bl;
    dcb = d;
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) begin
      hg[l] = '0; moff[l] = 0; mlock[l] = 0; ebit[l] = 0; quiet[l] = 0;
    end
    clear_model();
    dly[0] = 0; dly[1] = 1; dly[2] = 2; dly[3] = 5;
    quiet[3] = 1;
    repeat (3) @(negedge clk);
    chk("R1", int'(offset_o), 0, "reset offsets");
    chk("R1", int'(lock_o), 0, "reset lock");
    chk("R1", int'(bit_o), 0, "reset bits");
    rst = 1'b0;
    repeat (3) step(0, 1, "R7");
    // one window; lane 3 constant, so it must stay unlocked
    repeat (4) step(1, 1, "R3");
    repeat (2) step(0, 1, "R9");
    quiet[3] = 0;
    // shortened blanking is discarded
    dly[0] = 4; dly[1] = 7;
    repeat (2) step(1, 1, "R7");
    repeat (3) step(0, 1, "R7");
    // sweep delays: lane 0 upward, lane 1 downward, lane 2 fixed
    for (int w = 0; w < 14; w++) begin
      dly[0] = w % 9; dly[1] = 8 - (w % 9); dly[2] = 4; dly[3] = (w * 5) % 9;
      repeat (4) step(1, 1, (w % 2) ? "R5" : "R4");
      repeat (2) step(0, 1, "R6");
    end
    // long blanking: back-to-back windows
    for (int i = 0; i < 12; i++) begin
      if (i % 4 == 0) begin dly[0] = (dly[0] + 1) % 9; dly[3] = (dly[3] + 2) % 9; end
      step(1, 1, "R10");
    end
    step(0, 1, "R10");
    // DC balance off: centre slot, no training
    repeat (6) step(1, 0, "R8");
    step(0, 1, "R8");
    repeat (4) step(1, 1, "R8");
    repeat (2) step(0, 1, "R3");
    // reset during operation
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", int'(offset_o), 0, "reset offsets");
    chk("R1", int'(lock_o), 0, "reset lock");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule